// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block sits between a transmit MAC and system memory. Software builds a ring of two-word descriptors, writes the ring's start address into the queue base register, and kicks the engine by writing the control word with both the enable and the go bit set. The engine then walks the ring. For each descriptor it reads the buffer address and the status word. It reads the buffer one 32-bit word at a time and hands the bytes, least significant first, to the MAC over a valid/ready byte stream. The final byte of a frame carries a last marker.

When a frame is complete, the engine marks the frame's first descriptor as used and raises a sticky transmit-complete flag. It then moves on to the next descriptor. It halts when it meets a descriptor that software has not handed over, that is, one whose used flag is still set. If such a descriptor appears in the middle of a frame, the frame is aborted and reported as buffer exhaustion. A buffer word that arrives too late in the middle of a frame is reported as an underrun. Framing, padding and CRC belong to the MAC and are not handled here.

Top module: `txq_fetch`

## Requirements
- R1: After reset the control, status and queue base registers (register addresses 0, 1 and 2) read as zero. No memory request, stream byte or abort pulse is driven.
- R2: The engine starts only when a single write to control sets both bit 9 (go) and bit 3 (enable). It always starts at the queue base address. A go write while the engine is running has no effect.
- R3: A descriptor at byte address D is fetched as two reads: the buffer address from D and the status word from D+4. In the status word, bits 10:0 hold the byte length, bit 15 marks the last buffer of a frame, bit 30 is the wrap marker and bit 31 is the used flag.
- R4: Exactly length bytes are sent from each buffer, read as words from consecutive word addresses starting at the buffer address, byte 0 first from bits 7:0. tx_last is high only on the final byte of a buffer whose status has bit 15 set.
- R5: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values.
- R6: After descriptor D the next fetch is at D+8, or at the queue base when D has bit 30 set.
- R7: A descriptor with bit 31 already set that is met outside a frame stops the engine with no write, no abort and no completion.
- R8: When all bytes of a frame have been sent, the first descriptor's status word (D+4) is written back with bit 31 set and its other bits unchanged. Status register bit 5 is then set.
- R9: Status bit 5 is cleared by writing 1 to bit 5 of the status register. Writing 0 leaves it set.
- R10: A used descriptor met inside a frame writes the first descriptor's status with bits 31 and 27 set, pulses tx_abort, leaves status bit 5 unchanged and stops the engine.
- R11: A buffer word read other than the first of its frame that is not answered within UR_LIMIT cycles is discarded when it arrives. The first descriptor's status is then written with bits 31 and 28 set, tx_abort pulses and the engine stops.
- R12: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 queue base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_abort | output | 1 | One-cycle pulse: current frame aborted |

## Verification
The assertions check on every cycle the handshake properties. A pending memory request stays frozen until acknowledged. A stalled byte stays frozen until accepted. The serializer is only loaded when empty. Every descriptor write carries the used flag, and no byte is offered during an abort pulse. Byte order, buffer lengths, ring wrap, the halt rules and which write-back codes appear can only be shown by the bench's ring scenarios. In those scenarios a behavioural walk of the ring, run against a copy of memory, predicts every byte and every write.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int WORD_W = 32;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_BASE = 2'd2;

  localparam int CTRL_EN_BIT   = 3;
  localparam int CTRL_GO_BIT   = 9;
  localparam int STAT_DONE_BIT = 5;

  localparam int D_LAST_BIT = 15;
  localparam int D_WRAP_BIT = 30;

  localparam logic [WORD_W-1:0] M_USED = 32'h8000_0000;
  localparam logic [WORD_W-1:0] M_EXH  = 32'h0800_0000;
  localparam logic [WORD_W-1:0] M_UR   = 32'h1000_0000;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_W0, S_RD_W1, S_RD_DATA, S_SEND, S_BUF_END, S_WB
  } txq_state_e;

  typedef enum logic [1:0] {
    WB_DONE, WB_EXH, WB_UR
  } txq_wb_e;
endpackage

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done_set,
  output logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] base,
  output logic              start_p
);
  logic en_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      base    <= '0;
      start_p <= 1'b0;
      rdata   <= '0;
    end else begin
      start_p <= 1'b0;
      if (wr && addr == RA_CTRL) begin
        en_q    <= wdata[CTRL_EN_BIT];
        start_p <= wdata[CTRL_GO_BIT] && wdata[CTRL_EN_BIT];
      end
      if (wr && addr == RA_BASE) base <= wdata[ADDR_W-1:0];
      if (done_set) done_q <= 1'b1;
      else if (wr && addr == RA_STAT && wdata[STAT_DONE_BIT]) done_q <= 1'b0;

      rdata <= '0;
      case (addr)
        RA_CTRL: rdata[CTRL_EN_BIT]   <= en_q;
        RA_STAT: rdata[STAT_DONE_BIT] <= done_q;
        RA_BASE: rdata                <= WORD_W'(base);
        default: rdata                <= '0;
      endcase
    end
  end
endmodule

// File: rtl/txq_ur_timer.sv
module txq_ur_timer #(
  parameter int LIMIT = 8,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hit,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || hit) cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/txq_byte_out.sv
module txq_byte_out #(
  parameter int BPW = 4,
  localparam int NB_W = $clog2(BPW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [8*BPW-1:0] load_word,
  input  logic [NB_W-1:0]  load_n,
  input  logic             load_last,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             busy
);
  logic [8*BPW-1:0] word_q;
  logic [NB_W-1:0]  cnt_q;
  logic             mark_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      cnt_q   <= '0;
      mark_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (load) begin
      word_q  <= load_word;
      cnt_q   <= load_n;
      mark_q  <= load_last;
      valid_q <= 1'b1;
    end else if (valid_q && tx_ready) begin
      word_q <= word_q >> 8;
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == NB_W'(1)) valid_q <= 1'b0;
    end
  end

  assign tx_data  = word_q[7:0];
  assign tx_valid = valid_q;
  assign tx_last  = valid_q && mark_q && (cnt_q == NB_W'(1));
  assign busy     = valid_q;

  // R5
  stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid_q);
endmodule

// File: rtl/txq_fetch.sv
module txq_fetch
  import txq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 11,
  parameter int UR_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              tx_abort
);
  localparam int BPW  = WORD_W / 8;
  localparam int NB_W = $clog2(BPW + 1);

  txq_state_e        state_q;
  txq_wb_e           kind_q;
  logic [ADDR_W-1:0] base;
  logic              start_p;
  logic              done_set;
  logic [ADDR_W-1:0] desc_q;
  logic [ADDR_W-1:0] buf_q;
  logic [ADDR_W-1:0] first_q;
  logic [WORD_W-1:0] first_stat_q;
  logic [LEN_W-1:0]  rem_q;
  logic              cur_last_q;
  logic              cur_wrap_q;
  logic              in_frame_q;
  logic              frame_data_q;
  logic              ur_q;
  logic              ur_exp;
  logic              abort_q;
  logic              out_busy;
  logic              load;
  logic [NB_W-1:0]   nb;
  logic              nb_last;
  logic [ADDR_W-1:0] next_desc;
  logic [WORD_W-1:0] wb_word;

  txq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .done_set(done_set), .rdata(reg_rdata), .base(base), .start_p(start_p)
  );

  txq_ur_timer #(.LIMIT(UR_LIMIT)) u_timer (
    .clk(clk), .rst(rst),
    .run(state_q == S_RD_DATA && frame_data_q),
    .hit(mem_ack), .expired(ur_exp)
  );

  txq_byte_out #(.BPW(BPW)) u_out (
    .clk(clk), .rst(rst), .load(load), .load_word(mem_rdata), .load_n(nb),
    .load_last(nb_last), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .busy(out_busy)
  );

  assign nb        = (rem_q >= LEN_W'(BPW)) ? NB_W'(BPW) : rem_q[NB_W-1:0];
  assign nb_last   = cur_last_q && (rem_q <= LEN_W'(BPW));
  assign load      = (state_q == S_RD_DATA) && mem_ack && !(ur_q || ur_exp);
  assign next_desc = cur_wrap_q ? base : desc_q + ADDR_W'(8);
  assign done_set  = (state_q == S_WB) && mem_ack && (kind_q == WB_DONE);

  always_comb begin
    wb_word = first_stat_q | M_USED;
    if (kind_q == WB_EXH) wb_word = wb_word | M_EXH;
    if (kind_q == WB_UR)  wb_word = wb_word | M_UR;
  end

  assign mem_req   = (state_q == S_RD_W0) || (state_q == S_RD_W1) ||
                     (state_q == S_RD_DATA) || (state_q == S_WB);
  assign mem_we    = (state_q == S_WB);
  assign mem_wdata = wb_word;
  assign tx_abort  = abort_q;

  always_comb begin
    case (state_q)
      S_RD_W1:   mem_addr = desc_q + ADDR_W'(4);
      S_RD_DATA: mem_addr = buf_q;
      S_WB:      mem_addr = first_q + ADDR_W'(4);
      default:   mem_addr = desc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      kind_q       <= WB_DONE;
      desc_q       <= '0;
      buf_q        <= '0;
      first_q      <= '0;
      first_stat_q <= '0;
      rem_q        <= '0;
      cur_last_q   <= 1'b0;
      cur_wrap_q   <= 1'b0;
      in_frame_q   <= 1'b0;
      frame_data_q <= 1'b0;
      ur_q         <= 1'b0;
      abort_q      <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_p) begin
            desc_q     <= base;
            in_frame_q <= 1'b0;
            ur_q       <= 1'b0;
            state_q    <= S_RD_W0;
          end
        end
        S_RD_W0: begin
          if (mem_ack) begin
            buf_q   <= {mem_rdata[ADDR_W-1:2], 2'b00};
            state_q <= S_RD_W1;
          end
        end
        S_RD_W1: begin
          if (mem_ack) begin
            cur_last_q <= mem_rdata[D_LAST_BIT];
            cur_wrap_q <= mem_rdata[D_WRAP_BIT];
            if ((mem_rdata & M_USED) != '0) begin
              if (in_frame_q) begin
                kind_q  <= WB_EXH;
                abort_q <= 1'b1;
                state_q <= S_WB;
              end else begin
                state_q <= S_IDLE;
              end
            end else begin
              if (!in_frame_q) begin
                first_q      <= desc_q;
                first_stat_q <= mem_rdata;
                in_frame_q   <= 1'b1;
                frame_data_q <= 1'b0;
              end
              rem_q <= mem_rdata[LEN_W-1:0];
              if (mem_rdata[LEN_W-1:0] == '0) state_q <= S_BUF_END;
              else                            state_q <= S_RD_DATA;
            end
          end
        end
        S_RD_DATA: begin
          if (ur_exp) ur_q <= 1'b1;
          if (mem_ack) begin
            if (ur_q || ur_exp) begin
              ur_q    <= 1'b0;
              kind_q  <= WB_UR;
              abort_q <= 1'b1;
              state_q <= S_WB;
            end else begin
              rem_q        <= rem_q - LEN_W'(nb);
              buf_q        <= buf_q + ADDR_W'(BPW);
              frame_data_q <= 1'b1;
              state_q      <= S_SEND;
            end
          end
        end
        S_SEND: begin
          if (!out_busy) state_q <= (rem_q == '0) ? S_BUF_END : S_RD_DATA;
        end
        S_BUF_END: begin
          if (cur_last_q) begin
            kind_q  <= WB_DONE;
            state_q <= S_WB;
          end else begin
            desc_q  <= next_desc;
            state_q <= S_RD_W0;
          end
        end
        S_WB: begin
          if (mem_ack) begin
            in_frame_q <= 1'b0;
            if (kind_q == WB_DONE) begin
              desc_q  <= next_desc;
              state_q <= S_RD_W0;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8
  wb_used_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[31]);

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> !tx_valid);

  // R11
  abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !tx_abort);
endmodule

// File: tb/txq_fetch_tb.sv
`timescale 1ns/1ps
module txq_fetch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_abort;
  logic        tx_ready = 1'b1;

  always #2 clk = ~clk;

  txq_fetch u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_abort(tx_abort)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] mem [0:255];
  logic [31:0] pm  [0:255];
  logic [8:0]  exp_q[$];
  logic [63:0] expw_q[$];
  int exp_abort, abort_seen, exp_done;
  int lat = 1;
  logic [31:0] slow_addr = 32'hFFFF_FFFF;
  bit stall = 1'b0;
  int cyc = 0;
  int wcnt = 0;
  bit req_seen = 1'b0;
  bit prev_stall = 1'b0;
  logic [7:0] prev_data;
  logic prev_last;
  logic [8:0]  e_v;
  logic [63:0] w_v;
  string tag = "R4";
  string wtag = "R8";
  logic [31:0] rd;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory, stream sink and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst && prev_stall)
      check(tx_valid && tx_data == prev_data && tx_last == prev_last, "R5",
            "stalled byte held", {tx_valid, tx_last, tx_data}, {2'b10, prev_data});
    tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
    if (!rst && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check(1'b0, tag, "unexpected byte", {tx_last, tx_data}, 0);
      else begin
        e_v = exp_q.pop_front();
        check({tx_last, tx_data} == e_v, tag, "stream byte", {tx_last, tx_data}, e_v);
      end
    end
    prev_stall = !rst && tx_valid && !tx_ready;
    prev_data  = tx_data;
    prev_last  = tx_last;
    if (!rst && tx_abort) abort_seen++;
    if (!rst && mem_req) req_seen = 1'b1;
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (!rst && mem_req) begin
      wcnt++;
      if (wcnt >= ((!mem_we && mem_addr == slow_addr) ? 20 : lat)) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          if (expw_q.size() == 0)
            check(1'b0, wtag, "unexpected write", {mem_addr, mem_wdata}, 0);
          else begin
            w_v = expw_q.pop_front();
            check({mem_addr, mem_wdata} == w_v, wtag, "descriptor write-back",
                  {mem_addr, mem_wdata}, w_v);
          end
          mem[mem_addr[9:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[9:2]];
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    expw_q.delete();
    exp_abort = 0; abort_seen = 0; exp_done = 0;
    lat = 1; slow_addr = 32'hFFFF_FFFF; stall = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++)
      mem[i] = (32'h03020100 + i * 32'h04040404) ^ 32'h5A5A5A5A;
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
  endtask

  task automatic set_desc(input logic [31:0] d, input logic [31:0] a, input logic [31:0] s);
    mem[d[9:2]] = a;
    mem[8'(d[9:2] + 8'd1)] = s;
  endtask

  // Walks the ring on a copy of memory and predicts bytes, writes, aborts
  task automatic predict(input logic [31:0] base);
    logic [31:0] cur, w0, st, first, fst, a, word, t;
    bit inf, stop;
    int fw, len;
    for (int i = 0; i < 256; i++) pm[i] = mem[i];
    cur = base; inf = 0; stop = 0; fw = 0; first = 0; fst = 0;
    for (int g = 0; g < 64 && !stop; g++) begin
      w0 = pm[cur[9:2]];
      st = pm[8'(cur[9:2] + 8'd1)];
      if (st[31]) begin
        if (inf) begin
          expw_q.push_back({first + 32'd4, fst | 32'h8800_0000});
          exp_abort++;
        end
        stop = 1;
      end else begin
        if (!inf) begin inf = 1; first = cur; fst = st; fw = 0; end
        len = int'(st[10:0]);
        a = {w0[31:2], 2'b00};
        for (int k = 0; k < len && !stop; k += 4) begin
          if (fw > 0 && a == slow_addr) begin
            expw_q.push_back({first + 32'd4, fst | 32'h9000_0000});
            exp_abort++;
            stop = 1;
          end else begin
            fw++;
            word = pm[a[9:2]];
            for (int b = 0; b < 4 && k + b < len; b++)
              exp_q.push_back({st[15] && (k + b == len - 1), word[8*b +: 8]});
            a += 32'd4;
          end
        end
        if (!stop) begin
          if (st[15]) begin
            t = first + 32'd4;
            expw_q.push_back({t, fst | 32'h8000_0000});
            pm[t[9:2]] = fst | 32'h8000_0000;
            exp_done++;
            inf = 0;
          end
          cur = st[30] ? base : cur + 32'd8;
        end
      end
    end
  endtask

  task automatic wait_idle();
    int q;
    repeat (4) @(negedge clk);
    q = 0;
    while (q < 6) begin
      @(negedge clk);
      if (!mem_req && !tx_valid) q++;
      else q = 0;
    end
  endtask

  task automatic end_scn(input string req);
    check(exp_q.size() == 0, "R4", "bytes still expected", exp_q.size(), 0);
    check(expw_q.size() == 0, "R8", "writes still expected", expw_q.size(), 0);
    check(abort_seen == exp_abort, req, "abort pulses", abort_seen, exp_abort);
    reg_read(2'd1, rd);
    check(rd[5] == (exp_done > 0), req, "status done bit", rd[5], exp_done > 0);
  endtask

  initial begin
    fill_mem();
    do_reset();
    // R1: reset state
    check(!mem_req && !tx_valid && !tx_abort, "R1", "idle outputs",
          {mem_req, tx_valid, tx_abort}, 0);
    for (int r = 0; r < 3; r++) begin
      reg_read(2'(r), rd);
      check(rd == 0, "R1", "register after reset", rd, 0);
    end

    // R2: go without enable does nothing
    set_desc(32'h0, 32'h100, 32'h0000_8007);
    set_desc(32'h8, 32'h0, 32'h8000_0000);
    req_seen = 1'b0;
    reg_write(2'd0, 32'h0000_0200);
    repeat (20) @(negedge clk);
    check(!req_seen, "R2", "no fetch without enable", req_seen, 0);

    // R3 R4 R6 R8: single frame, then halt on used descriptor
    tag = "R3"; wtag = "R8";
    predict(32'h0);
    reg_write(2'd0, 32'h0000_0208);
    wait_idle();
    end_scn("R8");
    reg_read(2'd0, rd);
    check(rd == 32'h8, "R2", "enable readback", rd, 32'h8);

    // R7: first descriptor already used
    do_reset();
    fill_mem();
    set_desc(32'h0, 32'h100, 32'h8000_8004);
    tag = "R7"; wtag = "R7";
    predict(32'h0);
    reg_write(2'd0, 32'h0000_0208);
    wait_idle();
    end_scn("R7");

    // R6 R5 R2: multi-buffer frame, wrap back to base, stalls, extra go ignored
    do_reset();
    fill_mem();
    set_desc(32'h40, 32'h120, 32'h0000_0005);
    set_desc(32'h48, 32'h140, 32'h0000_8003);
    set_desc(32'h50, 32'h160, 32'h4000_8004);
    lat = 3; stall = 1'b1;
    tag = "R6"; wtag = "R6";
    reg_write(2'd2, 32'h40);
    reg_read(2'd2, rd);
    check(rd == 32'h40, "R2", "queue base readback", rd, 32'h40);
    predict(32'h40);
    reg_write(2'd0, 32'h0000_0208);
    repeat (10) @(negedge clk);
    reg_write(2'd0, 32'h0000_0208);   // R2: ignored while running
    wait_idle();
    end_scn("R6");
    // R9: write-one-to-clear
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, rd);
    check(rd[5] == 1'b1, "R9", "done kept on write 0", rd[5], 1);
    reg_write(2'd1, 32'h20);
    reg_read(2'd1, rd);
    check(rd[5] == 1'b0, "R9", "done cleared on write 1", rd[5], 0);

    // R10: used descriptor inside a frame
    do_reset();
    fill_mem();
    set_desc(32'h0, 32'h100, 32'h0000_0006);
    set_desc(32'h8, 32'h0, 32'h8000_0000);
    tag = "R10"; wtag = "R10";
    predict(32'h0);
    reg_write(2'd0, 32'h0000_0208);
    wait_idle();
    end_scn("R10");

    // R11: late buffer word mid-frame
    do_reset();
    fill_mem();
    set_desc(32'h0, 32'h100, 32'h0000_800C);
    slow_addr = 32'h104;
    tag = "R11"; wtag = "R11";
    predict(32'h0);
    reg_write(2'd0, 32'h0000_0208);
    wait_idle();
    end_scn("R11");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule